// File: doc/BRIEF.md
# Serial Link Power-State Sequencer

This block decides which operating state one end of a serial video link is in and what the link drivers may do in that state. It takes register-level enables, a power-down pin, a pixel-clock-valid flag, a receiver lock flag and a remote wake event. From these it walks through power-down, idle, configuration link, video link, PRBS test, sleep and a timed wake window. It reports the current state as a 3-bit code and drives two gates. The first enables the forward serial driver. The second enables the reverse control channel.

The reverse control channel is held off for a fixed interval after power-up. It is also held off for a shorter interval after every start or stop of the forward link, so that a receiver retraining on the forward stream is not disturbed. A remote wake event opens a window. If the sleep request is not withdrawn before the window closes, the block drops back into sleep. All intervals are counted in a prescaled tick input, and each limit is a parameter given in ticks. On the way out of power-down, the static configuration pin levels are captured as the configuration defaults.

Top module: `link_power_seq`

## Requirements
- R1: While `pwdnN` is low, the state moves to power-down (code 0) at the next clock edge from any state. In power-down, `cfgDefault` is cleared to zero, `fwdDrvEn` is low and `revChanEn` is low.
- R2: At the edge that leaves power-down (pin high), the state becomes idle (code 1) and `cfgDefault` captures the value on `cfgPins`.
- R3: From idle or configuration link, `serEnReg` set together with `pclkValid` high enters the video link (code 3). From the video link or PRBS test, losing either signal returns the block to idle.
- R4: From idle, `serEnReg` clear with `cfgLinkEnReg` set enters the configuration link (code 2). Clearing `cfgLinkEnReg` returns the block to idle.
- R5: `fwdDrvEn` is high exactly while the state is configuration link, video link or PRBS test.
- R6: `revChanEn` stays low after power-down is left, until `PUP_TICKS` ticks have been counted.
- R7: Each time `fwdDrvEn` changes, `revChanEn` goes low at the same edge. It stays low until `BLANK_TICKS` ticks have been counted from that edge.
- R8: `sleepReg` set in idle, configuration link, video link or PRBS test enters sleep (code 5). In sleep, `wakeEvt` enters the wake window (code 6).
- R9: In the wake window, clearing `sleepReg` leads to idle. If `sleepReg` is still set once `WAKE_TICKS` ticks have passed since the wake event, the block returns to sleep.
- R10: The PRBS test state (code 4) is entered only from the video link, with `prbsEnReg` and `rxLock` both high. Clearing `prbsEnReg` returns the block to the video link. `prbsEnReg` has no effect in the other states.
- R11: A cycle with `tick` low advances none of the three timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwdnN | input | 1 | Power-down pin, active low |
| tick | input | 1 | One-cycle prescaled timer tick |
| serEnReg | input | 1 | Serial link enable register bit |
| cfgLinkEnReg | input | 1 | Configuration link enable register bit |
| sleepReg | input | 1 | Sleep request register bit |
| prbsEnReg | input | 1 | PRBS test enable register bit |
| pclkValid | input | 1 | Pixel clock present and valid |
| rxLock | input | 1 | Receiver lock flag |
| wakeEvt | input | 1 | Wake event seen while sleeping |
| cfgPins | input | CFG_W | Static configuration pin levels |
| linkState | output | 3 | Current state code |
| fwdDrvEn | output | 1 | Forward serial driver enable |
| revChanEn | output | 1 | Reverse control channel enable |
| cfgDefault | output | CFG_W | Configuration defaults captured at power-up |

## Verification
A wrong state shows up on `linkState` in the very next cycle. It also reaches `fwdDrvEn` in that cycle whenever the wrong state differs in its driver class. A timer that loads or counts wrongly stays hidden until its window should close. It then appears as `revChanEn` rising early or late, or as the wake window resolving one or more cycles off. For that reason the bench compares every output against a behavioural model on every cycle, with gaps in the tick stream inside some windows.

// File: rtl/lnkpwr_pkg.sv
package lnkpwr_pkg;

  typedef enum logic [2:0] {
    LS_PWRDN = 3'd0,
    LS_IDLE  = 3'd1,
    LS_CFG   = 3'd2,
    LS_VIDEO = 3'd3,
    LS_PRBS  = 3'd4,
    LS_SLEEP = 3'd5,
    LS_WAKE  = 3'd6
  } lnkState_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic pupLoad;
    logic blankClear;
    logic blankLoad;
    logic wakeLoad;
  } tmrCtl_t;

  // status returned by the timer datapath
  typedef struct packed {
    logic pupDone;
    logic blankDone;
    logic wakeExpired;
  } tmrStat_t;

  function automatic logic fwdActive(input lnkState_e s);
    return (s == LS_CFG) || (s == LS_VIDEO) || (s == LS_PRBS);
  endfunction

endpackage

// File: rtl/lnkpwr_downcnt.sv
module lnkpwr_downcnt #(
  parameter int unsigned LIMIT      = 500,
  parameter bit          RESET_FULL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic load,
  input  logic tick,
  output logic isZero
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);
  localparam logic [CW-1:0] RSTV = RESET_FULL ? FULL : '0;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= RSTV;
    else if (clear)                cnt <= '0;
    else if (load)                 cnt <= FULL;
    else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign isZero = (cnt == '0);

  // R11: without a tick, and with no clear or load, the count holds
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tick) && !$past(clear) && !$past(load)) |-> $stable(cnt));
endmodule

// File: rtl/lnkpwr_timers.sv
module lnkpwr_timers import lnkpwr_pkg::*; #(
  parameter int unsigned PUP_TICKS   = 2000,
  parameter int unsigned BLANK_TICKS = 500,
  parameter int unsigned WAKE_TICKS  = 8000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  tmrCtl_t  ctl,
  output tmrStat_t stat
);
  localparam int NTMR = 3;
  localparam int unsigned LIMITS [NTMR] = '{PUP_TICKS, BLANK_TICKS, WAKE_TICKS};
  localparam bit RSTFULL [NTMR] = '{1'b1, 1'b0, 1'b0};

  logic [NTMR-1:0] clrVec, ldVec, zeroVec;

  assign clrVec = {1'b0, ctl.blankClear, 1'b0};
  assign ldVec  = {ctl.wakeLoad, ctl.blankLoad, ctl.pupLoad};

  for (genvar g = 0; g < NTMR; g++) begin : gTmr
    lnkpwr_downcnt #(.LIMIT(LIMITS[g]), .RESET_FULL(RSTFULL[g])) cnt_i (
      .clk(clk), .rstN(rstN), .clear(clrVec[g]), .load(ldVec[g]),
      .tick(tick), .isZero(zeroVec[g])
    );
  end

  assign stat.pupDone     = zeroVec[0];
  assign stat.blankDone   = zeroVec[1];
  assign stat.wakeExpired = zeroVec[2];
endmodule

// File: rtl/lnkpwr_ctrl.sv
module lnkpwr_ctrl import lnkpwr_pkg::*; #(
  parameter int unsigned CFG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwdnN,
  input  logic             serEn,
  input  logic             cfgLinkEn,
  input  logic             sleepReq,
  input  logic             prbsEn,
  input  logic             pclkValid,
  input  logic             rxLock,
  input  logic             wakeEvt,
  input  logic [CFG_W-1:0] cfgPins,
  input  tmrStat_t         tmr,
  output lnkState_e        state,
  output logic             fwdOn,
  output logic [CFG_W-1:0] cfgLatched,
  output tmrCtl_t          ctl
);
  lnkState_e nxt;
  logic linkUp;

  assign linkUp = serEn && pclkValid;

  always_comb begin
    nxt = state;
    if (!pwdnN) nxt = LS_PWRDN;
    else begin
      case (state)
        LS_PWRDN: nxt = LS_IDLE;
        LS_IDLE, LS_CFG: begin
          if (sleepReq)                nxt = LS_SLEEP;
          else if (linkUp)             nxt = LS_VIDEO;
          else if (!serEn && cfgLinkEn) nxt = LS_CFG;
          else                         nxt = LS_IDLE;
        end
        LS_VIDEO: begin
          if (sleepReq)               nxt = LS_SLEEP;
          else if (!linkUp)           nxt = LS_IDLE;
          else if (prbsEn && rxLock)  nxt = LS_PRBS;
        end
        LS_PRBS: begin
          if (sleepReq)      nxt = LS_SLEEP;
          else if (!linkUp)  nxt = LS_IDLE;
          else if (!prbsEn)  nxt = LS_VIDEO;
        end
        LS_SLEEP: if (wakeEvt) nxt = LS_WAKE;
        LS_WAKE: begin
          if (!sleepReq)            nxt = LS_IDLE;
          else if (tmr.wakeExpired) nxt = LS_SLEEP;
        end
        default: nxt = LS_PWRDN;  // unused code recovers to power-down
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LS_PWRDN;
    else       state <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cfgLatched <= '0;
    else if (!pwdnN)            cfgLatched <= '0;
    else if (state == LS_PWRDN) cfgLatched <= cfgPins;
  end

  assign fwdOn          = fwdActive(state);
  assign ctl.pupLoad    = (state == LS_PWRDN);
  assign ctl.blankClear = (state == LS_PWRDN);
  assign ctl.blankLoad  = fwdActive(nxt) != fwdActive(state);
  assign ctl.wakeLoad   = (state == LS_SLEEP) && wakeEvt;

  // R1: power-down pin low forces power-down on the next edge
  a_r1_pwdn_forces: assert property (@(posedge clk) disable iff (!rstN)
    !pwdnN |=> (state == LS_PWRDN));
  // R10: PRBS test is only reachable from the video link
  a_r10_prbs_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == LS_PRBS) |-> ($past(state) == LS_PRBS || $past(state) == LS_VIDEO));
  // R9: the wake window only resolves to idle, sleep or power-down
  a_r9_wake_exit: assert property (@(posedge clk) disable iff (!rstN)
    (($past(state) == LS_WAKE) && (state != LS_WAKE)) |->
      (state == LS_IDLE || state == LS_SLEEP || state == LS_PWRDN));
endmodule

// File: rtl/link_power_seq.sv
module link_power_seq import lnkpwr_pkg::*; #(
  parameter int unsigned CFG_W       = 6,
  parameter int unsigned PUP_TICKS   = 2000,
  parameter int unsigned BLANK_TICKS = 500,
  parameter int unsigned WAKE_TICKS  = 8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwdnN,
  input  logic             tick,
  input  logic             serEnReg,
  input  logic             cfgLinkEnReg,
  input  logic             sleepReg,
  input  logic             prbsEnReg,
  input  logic             pclkValid,
  input  logic             rxLock,
  input  logic             wakeEvt,
  input  logic [CFG_W-1:0] cfgPins,
  output logic [2:0]       linkState,
  output logic             fwdDrvEn,
  output logic             revChanEn,
  output logic [CFG_W-1:0] cfgDefault
);
  lnkState_e state;
  tmrCtl_t   ctl;
  tmrStat_t  stat;

  lnkpwr_ctrl #(.CFG_W(CFG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pwdnN(pwdnN), .serEn(serEnReg),
    .cfgLinkEn(cfgLinkEnReg), .sleepReq(sleepReg), .prbsEn(prbsEnReg),
    .pclkValid(pclkValid), .rxLock(rxLock), .wakeEvt(wakeEvt),
    .cfgPins(cfgPins), .tmr(stat), .state(state), .fwdOn(fwdDrvEn),
    .cfgLatched(cfgDefault), .ctl(ctl)
  );

  lnkpwr_timers #(.PUP_TICKS(PUP_TICKS), .BLANK_TICKS(BLANK_TICKS),
                  .WAKE_TICKS(WAKE_TICKS)) timers_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .stat(stat)
  );

  assign linkState = state;
  assign revChanEn = (state != LS_PWRDN) && stat.pupDone && stat.blankDone;

  // R7: a forward link start or stop closes the reverse channel at once
  a_r7_blank_on_toggle: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fwdDrvEn) |-> !revChanEn);
  // R6: first cycle out of power-down never has the reverse channel open
  a_r6_pup_closed: assert property (@(posedge clk) disable iff (!rstN)
    ($past(linkState) == 3'd0 && linkState != 3'd0) |-> !revChanEn);
endmodule

// File: tb/link_power_seq_tb_top.sv
module link_power_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 6;
  localparam int PUP = 20;
  localparam int BLANK = 8;
  localparam int WAKE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwdnN = 1'b0, tick = 1'b0, serEnReg = 1'b0, cfgLinkEnReg = 1'b0;
  logic sleepReg = 1'b0, prbsEnReg = 1'b0, pclkValid = 1'b0, rxLock = 1'b0;
  logic wakeEvt = 1'b0;
  logic [CFG_W-1:0] cfgPins = '0;
  logic [2:0] linkState;
  logic fwdDrvEn, revChanEn;
  logic [CFG_W-1:0] cfgDefault;

  int tests = 0, fails = 0, cycCount = 0;
  bit tickGap = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  link_power_seq #(.CFG_W(CFG_W), .PUP_TICKS(PUP), .BLANK_TICKS(BLANK),
                   .WAKE_TICKS(WAKE)) dut_i (
    .clk(clk), .rstN(rstN), .pwdnN(pwdnN), .tick(tick), .serEnReg(serEnReg),
    .cfgLinkEnReg(cfgLinkEnReg), .sleepReg(sleepReg), .prbsEnReg(prbsEnReg),
    .pclkValid(pclkValid), .rxLock(rxLock), .wakeEvt(wakeEvt), .cfgPins(cfgPins),
    .linkState(linkState), .fwdDrvEn(fwdDrvEn), .revChanEn(revChanEn),
    .cfgDefault(cfgDefault)
  );

  // behavioural reference: state codes 0 pd,1 idle,2 cfg,3 video,4 prbs,5 sleep,6 wake
  int mState, mPup, mBlank, mWake;
  logic [CFG_W-1:0] mCfg;

  function automatic bit fwdOf(int s);
    return s == 2 || s == 3 || s == 4;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPup = PUP; mBlank = 0; mWake = 0; mCfg = '0;
    end else begin
      int ns;
      ns = mState;
      if (!pwdnN) ns = 0;
      else if (mState == 0) ns = 1;
      else if (mState == 1 || mState == 2) begin
        if (sleepReg) ns = 5;
        else if (serEnReg && pclkValid) ns = 3;
        else if (!serEnReg && cfgLinkEnReg) ns = 2;
        else ns = 1;
      end else if (mState == 3 || mState == 4) begin
        if (sleepReg) ns = 5;
        else if (!(serEnReg && pclkValid)) ns = 1;
        else if (mState == 3 && prbsEnReg && rxLock) ns = 4;
        else if (mState == 4 && !prbsEnReg) ns = 3;
      end else if (mState == 5) begin
        if (wakeEvt) ns = 6;
      end else if (mState == 6) begin
        if (!sleepReg) ns = 1;
        else if (mWake == 0) ns = 5;
      end
      if (mState == 0) mPup = PUP;
      else if (tick && mPup > 0) mPup--;
      if (mState == 0) mBlank = 0;
      else if (fwdOf(ns) != fwdOf(mState)) mBlank = BLANK;
      else if (tick && mBlank > 0) mBlank--;
      if (mState == 5 && wakeEvt) mWake = WAKE;
      else if (tick && mWake > 0) mWake--;
      if (!pwdnN) mCfg = '0;
      else if (mState == 0) mCfg = cfgPins;
      mState = ns;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    logic expRev;
    cycCount++;
    tick <= tickGap ? (cycCount % 3 == 0) : 1'b1;
    expRev = (mState != 0) && mPup == 0 && mBlank == 0;
    tests++;
    if (linkState !== 3'(mState) || fwdDrvEn !== fwdOf(mState) ||
        revChanEn !== expRev || cfgDefault !== mCfg) begin
      fails++;
      $display("FAIL %s cycle %0d: state/fwd/rev/cfg act %0d/%0b/%0b/%h exp %0d/%0b/%0b/%h",
               phase, cycCount, linkState, fwdDrvEn, revChanEn, cfgDefault,
               mState, fwdOf(mState), expRev, mCfg);
    end
    if (cycCount > 20000) begin
      fails++;
      $display("FAIL watchdog act running exp finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkState(string tag, int expS);
    @(negedge clk);
    tests++;
    if (linkState !== 3'(expS)) begin
      fails++;
      $display("FAIL %s directed: state act %0d exp %0d", tag, linkState, expS);
    end
  endtask

  initial begin
    phase = "R1";
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    checkState("R1", 0);
    phase = "R2";
    cfgPins = 6'b101101;
    pwdnN = 1'b1;
    waitCyc(2);
    checkState("R2", 1);
    phase = "R6";
    waitCyc(PUP + 4);
    phase = "R10";
    prbsEnReg = 1'b1; rxLock = 1'b1;
    waitCyc(4);
    checkState("R10", 1);
    prbsEnReg = 1'b0;
    phase = "R4";
    cfgLinkEnReg = 1'b1;
    waitCyc(2);
    checkState("R4", 2);
    phase = "R7";
    waitCyc(BLANK + 4);
    phase = "R3";
    serEnReg = 1'b1; pclkValid = 1'b1;
    waitCyc(2);
    checkState("R3", 3);
    waitCyc(5);
    pclkValid = 1'b0;
    phase = "R11";
    tickGap = 1'b1;
    waitCyc(BLANK * 3 + 6);
    tickGap = 1'b0;
    pclkValid = 1'b1;
    phase = "R10";
    waitCyc(BLANK + 4);
    prbsEnReg = 1'b1;
    waitCyc(2);
    checkState("R10", 4);
    phase = "R5";
    waitCyc(4);
    prbsEnReg = 1'b0;
    waitCyc(2);
    checkState("R10", 3);
    phase = "R8";
    sleepReg = 1'b1;
    waitCyc(2);
    checkState("R8", 5);
    waitCyc(BLANK + 2);
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    phase = "R9";
    checkState("R9", 6);
    waitCyc(WAKE + 4);
    checkState("R9", 5);
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    waitCyc(5);
    sleepReg = 1'b0;
    waitCyc(1);
    serEnReg = 1'b0; cfgLinkEnReg = 1'b0;
    phase = "R9";
    waitCyc(3);
    checkState("R9", 1);
    phase = "R1";
    serEnReg = 1'b1;
    waitCyc(6);
    pwdnN = 1'b0;
    waitCyc(2);
    checkState("R1", 0);
    phase = "R2";
    cfgPins = 6'b010011;
    pwdnN = 1'b1;
    waitCyc(PUP + BLANK + 6);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule